// File: doc/BRIEF.md
# Periodic Source-Fetch Request Controller

This block sits on the read side of a frame-processing datapath and pulls a frame's source data from system memory into a small ring of input FIFOs. Each FIFO holds one block. Software hands it one frame command (start address, length in blocks, request interval). From then on an interval timer paces the block: on each timer expiry it sizes a read request, issues it as a one-cycle address/length pulse, and moves its address and remaining-length bookkeeping forward.

A status table keeps the state of every FIFO slot. A request claims slots at the tail pointer. A bus-arrival strobe fills the slot at the head pointer. A drain notification from the consumer frees a filled slot. The slot that receives the frame's final block carries a last-block marker until it is drained. The size of each request is the smallest of three things: the blocks still owed, the bus burst limit, and the run of empty slots starting at the tail.

Top module: `src_fetch_ctrl`

## Requirements
- R1: A command accepted at clock edge E with interval I gives its first request opportunity so that req_valid is high in the cycle after edge E+I+1. Later opportunities come every I+1 cycles while the frame is active.
- R2: The request length is min(remaining blocks, MAX_BURST, number of consecutive empty slots counted in ring order from the tail slot). req_len never exceeds MAX_BURST and is never zero when req_valid is high.
- R3: If the computed length is zero, no request is issued and the timer starts a new interval. A request follows within one interval once a slot at the tail becomes empty.
- R4: cmd_valid is taken only while busy is low and cmd_len is nonzero. It loads the address and the remaining length and raises busy. A command while busy has no effect, and a zero-length command leaves the block idle.
- R5: The first request carries cmd_addr. Each request after it carries the previous address plus previous req_len times BLOCK_BYTES, and the remaining length falls by req_len.
- R6: req_last is high on the request that brings the remaining length to zero. busy falls at the same edge, and the slot receiving that final block gets its slot_last bit set.
- R7: slot_state holds 2 bits per slot at [2i+1:2i], with 0 = empty, 1 = requested, 2 = filled. A request marks slots tail..tail+req_len-1 (mod NUM_FIFO) as requested, and the tail moves forward by req_len.
- R8: data_arrive turns the head slot from requested to filled and moves the head forward by one. If the head slot is not in the requested state, data_arrive has no effect.
- R9: fifo_drain[i] turns slot i from filled to empty and clears its slot_last bit. A drain of a slot that is not filled has no effect.
- R10: Synchronous reset clears req_valid, req_last, busy, all slot states and markers, and both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Frame command strobe |
| cmd_addr | input | ADDR_W | Frame source start address (bytes) |
| cmd_len | input | LEN_W | Frame length in blocks |
| cmd_interval | input | IVL_W | Request interval I (period I+1 cycles) |
| data_arrive | input | 1 | One block landed in the head FIFO |
| fifo_drain | input | NUM_FIFO | Per-slot drain notification |
| req_valid | output | 1 | Request pulse |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | CNT_W | Request length in blocks |
| req_last | output | 1 | Request ends the frame |
| busy | output | 1 | Frame in progress |
| slot_state | output | 2*NUM_FIFO | Per-slot state table |
| slot_last | output | NUM_FIFO | Per-slot last-block marker |

## Verification
The bench sweeps frame lengths 1 to 9 against several intervals. It checks the spacing of every request, the split into MAX_BURST chunks, the address steps and which slot gets the last-block marker. A design that started counting one cycle late, or that dropped a short final chunk, would show wrong gaps, addresses or a missing req_last. A second run holds the slots full: a design that ignored the empty-slot limit would over-request, and one that counted empties outside the run at the tail would claim a slot that is still busy. Commands arriving while busy, drains of unfilled slots and arrivals with no outstanding request must leave the pointers and the table unchanged. Any leak shows up as a shifted address or a filled slot in the wrong place.

// File: rtl/src_fetch_pkg.sv
package src_fetch_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_REQ   = 2'd1,
    SLOT_FULL  = 2'd2
  } slot_st_t;
endpackage

// File: rtl/fetch_interval_timer.sv
module fetch_interval_timer #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [IVL_W-1:0] period,
  output logic             fire
);
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      period_q <= '0;
    end else if (load) begin
      cnt_q    <= period;
      period_q <= period;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= period_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire = run && (cnt_q == '0);

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= period_q); // R1
endmodule

// File: rtl/fetch_len_calc.sv
module fetch_len_calc #(
  parameter int NUM_FIFO  = 4,
  parameter int MAX_BURST = 3,
  parameter int LEN_W     = 16,
  localparam int PTR_W = $clog2(NUM_FIFO),
  localparam int CNT_W = $clog2(NUM_FIFO + 1)
) (
  input  logic [NUM_FIFO-1:0] slot_empty,
  input  logic [PTR_W-1:0]    tail,
  input  logic [LEN_W-1:0]    remaining,
  output logic [CNT_W-1:0]    len
);
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] cap;

  always_comb begin
    logic             alive;
    logic [PTR_W-1:0] idx;
    alive   = 1'b1;
    run_cnt = '0;
    for (int k = 0; k < NUM_FIFO; k++) begin
      idx     = tail + PTR_W'(k);
      alive   = alive & slot_empty[idx];
      run_cnt = run_cnt + CNT_W'(alive);
    end
  end

  assign cap = (run_cnt > CNT_W'(MAX_BURST)) ? CNT_W'(MAX_BURST) : run_cnt;
  assign len = (remaining < LEN_W'(cap)) ? CNT_W'(remaining) : cap;
endmodule

// File: rtl/fetch_status_table.sv
module fetch_status_table
  import src_fetch_pkg::*;
#(
  parameter int NUM_FIFO = 4,
  localparam int PTR_W = $clog2(NUM_FIFO),
  localparam int CNT_W = $clog2(NUM_FIFO + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue,
  input  logic [CNT_W-1:0]      issue_len,
  input  logic                  issue_last,
  input  logic                  arrive,
  input  logic [NUM_FIFO-1:0]   drain,
  output logic [2*NUM_FIFO-1:0] state_flat,
  output logic [NUM_FIFO-1:0]   last_flat,
  output logic [NUM_FIFO-1:0]   slot_empty,
  output logic [PTR_W-1:0]      tail,
  output logic [PTR_W-1:0]      head
);
  logic head_is_req;
  assign head_is_req = (state_flat[2*head +: 2] == SLOT_REQ);

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_slot
    slot_st_t         st;
    logic             lastf;
    logic [PTR_W-1:0] off;
    logic             hit;
    logic             last_hit;
    logic             arr_hit;

    assign off      = PTR_W'(i) - tail;
    assign hit      = issue && (CNT_W'(off) < issue_len);
    assign last_hit = hit && issue_last && (CNT_W'(off) == issue_len - 1'b1);
    assign arr_hit  = arrive && (head == PTR_W'(i)) && (st == SLOT_REQ);

    always_ff @(posedge clk) begin
      if (rst) begin
        st    <= SLOT_EMPTY;
        lastf <= 1'b0;
      end else if (hit) begin
        st    <= SLOT_REQ;
        lastf <= last_hit;
      end else if (arr_hit) begin
        st    <= SLOT_FULL;
      end else if (drain[i] && st == SLOT_FULL) begin
        st    <= SLOT_EMPTY;
        lastf <= 1'b0;
      end
    end

    assign state_flat[2*i +: 2] = st;
    assign last_flat[i]         = lastf;
    assign slot_empty[i]        = (st == SLOT_EMPTY);

    AST_ISSUE_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
      hit |-> st == SLOT_EMPTY); // R7
    AST_DRAIN_FREES: assert property (@(posedge clk) disable iff (rst)
      (drain[i] && st == SLOT_FULL && !hit) |=> st == SLOT_EMPTY && !lastf); // R9
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail <= '0;
      head <= '0;
    end else begin
      if (issue)                 tail <= tail + PTR_W'(issue_len);
      if (arrive && head_is_req) head <= head + 1'b1;
    end
  end

  AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (arrive && head_is_req) |=> head == PTR_W'($past(head) + 1'b1)); // R8
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!arrive || !head_is_req) |=> head == $past(head)); // R8
endmodule

// File: rtl/src_fetch_ctrl.sv
module src_fetch_ctrl #(
  parameter int NUM_FIFO    = 4,
  parameter int MAX_BURST   = 3,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int IVL_W       = 8,
  localparam int PTR_W = $clog2(NUM_FIFO),
  localparam int CNT_W = $clog2(NUM_FIFO + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [LEN_W-1:0]      cmd_len,
  input  logic [IVL_W-1:0]      cmd_interval,
  input  logic                  data_arrive,
  input  logic [NUM_FIFO-1:0]   fifo_drain,
  output logic                  req_valid,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [CNT_W-1:0]      req_len,
  output logic                  req_last,
  output logic                  busy,
  output logic [2*NUM_FIFO-1:0] slot_state,
  output logic [NUM_FIFO-1:0]   slot_last
);
  logic                accept;
  logic                tick;
  logic                issue;
  logic                issue_last;
  logic [CNT_W-1:0]    calc_len;
  logic [NUM_FIFO-1:0] slot_empty;
  logic [PTR_W-1:0]    tail;
  logic [PTR_W-1:0]    head;
  logic [ADDR_W-1:0]   next_addr;
  logic [LEN_W-1:0]    remaining;

  assign accept     = cmd_valid && !busy && (cmd_len != '0);
  assign issue      = tick && (calc_len != '0);
  assign issue_last = issue && (remaining == LEN_W'(calc_len));

  fetch_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .run    (busy),
    .period (cmd_interval),
    .fire   (tick)
  );

  fetch_len_calc #(
    .NUM_FIFO  (NUM_FIFO),
    .MAX_BURST (MAX_BURST),
    .LEN_W     (LEN_W)
  ) u_len (
    .slot_empty (slot_empty),
    .tail       (tail),
    .remaining  (remaining),
    .len        (calc_len)
  );

  fetch_status_table #(.NUM_FIFO(NUM_FIFO)) u_table (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_len  (calc_len),
    .issue_last (issue_last),
    .arrive     (data_arrive),
    .drain      (fifo_drain),
    .state_flat (slot_state),
    .last_flat  (slot_last),
    .slot_empty (slot_empty),
    .tail       (tail),
    .head       (head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      next_addr <= '0;
      remaining <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_len   <= '0;
      req_last  <= 1'b0;
    end else begin
      req_valid <= issue;
      if (accept) begin
        busy      <= 1'b1;
        next_addr <= cmd_addr;
        remaining <= cmd_len;
      end
      if (issue) begin
        req_addr  <= next_addr;
        req_len   <= calc_len;
        req_last  <= issue_last;
        next_addr <= next_addr + ADDR_W'(calc_len) * ADDR_W'(BLOCK_BYTES);
        remaining <= remaining - LEN_W'(calc_len);
        if (issue_last) busy <= 1'b0;
      end
    end
  end

  AST_REQ_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0) && (req_len <= CNT_W'(MAX_BURST))); // R2
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(busy)); // R4
  AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> remaining == $past(remaining) - LEN_W'(req_len)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> next_addr == req_addr + ADDR_W'(req_len) * ADDR_W'(BLOCK_BYTES)); // R5
  AST_LAST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_last == (remaining == '0)) && (req_last == !busy)); // R6
endmodule

// File: tb/sim_src_fetch_ctrl.sv
module sim_src_fetch_ctrl;
  localparam int NF = 4;
  localparam int MB = 3;
  localparam int BB = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic [7:0]  cmd_interval = '0;
  logic        data_arrive = 1'b0;
  logic [3:0]  fifo_drain = '0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [2:0]  req_len;
  logic        req_last;
  logic        busy;
  logic [7:0]  slot_state;
  logic [3:0]  slot_last;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int tb_tail = 0;
  int tb_head = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  src_fetch_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_interval(cmd_interval), .data_arrive(data_arrive),
    .fifo_drain(fifo_drain), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_last(req_last), .busy(busy),
    .slot_state(slot_state), .slot_last(slot_last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic issue_cmd(input int addr, input int len, input int ivl, output int acc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = addr; cmd_len = len[15:0]; cmd_interval = ivl[7:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic wait_req(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (req_valid) begin got = 1; break; end
    end
  endtask

  task automatic arrive_n(input int n);
    for (int j = 0; j < n; j++) begin
      data_arrive = 1'b1;
      @(negedge clk);
    end
    data_arrive = 1'b0;
  endtask

  task automatic drain_mask(input logic [3:0] m);
    fifo_drain = m;
    @(negedge clk);
    fifo_drain = '0;
  endtask

  function automatic int st(input int s);
    return int'(slot_state[2*s +: 2]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int  acc, prev, sent, explen, base, lslot;
    bit  got;
    int  ivls[3] = '{4, 6, 9};
    logic [3:0] m;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_valid == 0 && busy == 0 && req_last == 0, "R10", "req/busy after reset", {req_valid, busy, req_last}, 0);
    chk(slot_state == 0 && slot_last == 0, "R10", "table after reset", {slot_state, slot_last}, 0);

    // R4 zero-length command stays idle
    issue_cmd(32'h100, 0, 2, acc);
    chk(busy == 0, "R4", "busy after zero-length cmd", busy, 0);
    wait_req(10, got);
    chk(!got, "R4", "request after zero-length cmd", got, 0);

    // R8 arrival with nothing requested is ignored
    arrive_n(1);
    chk(slot_state == 0, "R8", "table after stray arrival", slot_state, 0);
    issue_cmd(32'h40, 1, 4, acc);
    wait_req(8, got);
    chk(got && req_len == 1 && req_last, "R6", "single-block frame req", {got, req_len, req_last}, 5'b1_001_1);
    chk(st(0) == 1, "R7", "slot0 requested", st(0), 1);
    arrive_n(1);
    chk(st(0) == 2, "R8", "slot0 filled (head did not move on stray)", st(0), 2);
    chk(slot_last == 4'b0001, "R6", "slot_last marker", slot_last, 1);
    drain_mask(4'b0001);
    chk(st(0) == 0 && slot_last == 0, "R9", "slot0 drained", {st(0), slot_last}, 0);
    tb_tail = 1; tb_head = 1;

    // Sweep: frame lengths x intervals, consumer always clears slots before next tick
    foreach (ivls[k]) begin
      for (int L = 1; L <= 9; L++) begin
        base = 32'h1000 + L * 32'h100 + ivls[k];
        issue_cmd(base, L, ivls[k], acc);
        chk(busy == 1, "R4", "busy after cmd", busy, 1);
        sent = 0; prev = acc;
        while (sent < L) begin
          wait_req(ivls[k] + 3, got);
          chk(got, "R1", "request present", got, 1);
          if (!got) break;
          chk(cyc - prev == ivls[k] + 1, "R1", "request spacing", cyc - prev, ivls[k] + 1);
          prev = cyc;
          explen = (L - sent < MB) ? L - sent : MB;
          chk(req_len == explen, "R2", "request length", req_len, explen);
          chk(req_addr == base + sent * BB, "R5", "request address", req_addr, base + sent * BB);
          chk(req_last == (sent + explen == L), "R6", "req_last", req_last, sent + explen == L);
          m = '0;
          for (int j = 0; j < explen; j++) m[(tb_tail + j) % NF] = 1'b1;
          for (int s = 0; s < NF; s++)
            chk(st(s) == (m[s] ? 1 : 0), "R7", "slot state after request", st(s), m[s] ? 1 : 0);
          if (sent + explen == L) begin
            lslot = (tb_tail + explen - 1) % NF;
            chk(slot_last == (4'b1 << lslot), "R6", "last marker slot", slot_last, 1 << lslot);
            chk(busy == 0, "R6", "busy drops on last", busy, 0);
          end
          tb_tail = (tb_tail + explen) % NF;
          sent += explen;
          arrive_n(explen);
          for (int s = 0; s < NF; s++)
            if (m[s]) chk(st(s) == 2, "R8", "slot filled", st(s), 2);
          drain_mask(m);
          chk(slot_state == 0 && slot_last == 0, "R9", "slots drained", {slot_state, slot_last}, 0);
        end
        wait_req(2 * ivls[k] + 2, got);
        chk(!got, "R6", "no request after frame end", got, 0);
      end
    end
    tb_head = tb_tail;

    // Slot-limited frame: no drains, interval 1
    base = 32'h8000;
    issue_cmd(base, 10, 1, acc);
    cmd_valid = 1'b1; cmd_addr = 32'hDEAD0000; cmd_len = 16'd5; cmd_interval = 8'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_req(4, got);
    chk(got && req_len == 3, "R2", "first slot-limited req", req_len, 3);
    chk(cyc - acc == 2, "R1", "first request delay", cyc - acc, 2);
    chk(req_addr == base, "R5", "first address", req_addr, base);
    wait_req(4, got);
    chk(got && req_len == 1, "R2", "empty-run limited req", req_len, 1);
    chk(req_addr == base + 3 * BB, "R4", "busy cmd ignored (address)", req_addr, base + 3 * BB);
    wait_req(8, got);
    chk(!got, "R3", "no request with no empty slot", got, 0);
    chk(slot_state == 8'h55, "R7", "all slots requested", slot_state, 8'h55);
    arrive_n(1);
    chk(st(tb_head) == 2, "R8", "head slot filled", st(tb_head), 2);
    drain_mask(4'b1 << ((tb_head + 1) % NF));
    chk(st((tb_head + 1) % NF) == 1, "R9", "drain of requested slot ignored", st((tb_head + 1) % NF), 1);
    wait_req(4, got);
    chk(!got, "R3", "still blocked", got, 0);
    drain_mask(4'b1 << tb_head);
    wait_req(3, got);
    chk(got && req_len == 1, "R3", "request resumes after drain", req_len, 1);
    chk(req_addr == base + 4 * BB, "R5", "resumed address", req_addr, base + 4 * BB);
    chk(st(tb_head) == 1, "R7", "tail wrapped to freed slot", st(tb_head), 1);

    // Reset in mid-frame
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && req_valid == 0, "R10", "busy after mid-frame reset", busy, 0);
    chk(slot_state == 0 && slot_last == 0, "R10", "table after mid-frame reset", slot_state, 0);
    wait_req(6, got);
    chk(!got, "R10", "no request after reset", got, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule